// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Issuer

The block takes one software-written interrupt command and turns it into a single outgoing inter-processor message. The command has an 8-bit vector, a 3-bit delivery mode, a level flag, a trigger flag, a 2-bit destination shorthand and a destination processor index. A write is accepted only while the block is idle. On an accepted write the block validates the fields, fixes up the vector where the mode requires it, and turns shorthand and index into a mask over the processors. It then presents the message on a valid/ready bus.

Once the message has been taken, the block waits for a response that either accepts or rejects it. A rejected message is re-sent automatically, except in start-up mode. Retries are bounded, and when the limit is exhausted the block gives up and raises a sticky abort flag. The other sticky flags report a reserved command, a vector that was forced to zero, a write that arrived while busy, and a start-up message that was dropped. A busy output is high for the whole life of a command.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: A write (`cmd_we_i`) while idle with a valid mode raises `busy_o` and `msg_valid_o` in the next cycle, carrying the resolved fields. `msg_valid_o` and every message field stay unchanged until a cycle in which `msg_ready_i` is high.
- R2: The mask has bit i set for processor i, and the shorthand selects it:
  - 00: only the bit given by `cmd_dest_i`
  - 01: only bit SELF_ID
  - 10: all bits
  - 11: all bits except SELF_ID
- R3: Mode 101 with level 0 and trigger 1 is a synchronization broadcast. Its mask is all ones and its vector is 0, whatever the shorthand and index hold.
- R4: Modes 010 (system management) and 101 (INIT) always send vector 0. If the written vector was nonzero, the sticky `warn_vec_o` is set.
- R5: Mode 100 (non-maskable) sends vector 0 and does not set `warn_vec_o`. Modes 000, 001 and 110 send the written vector unchanged.
- R6: The following writes send no message, leave `busy_o` low and set the sticky `err_rsvd_o`:
  - mode 011
  - mode 111
  - mode 101 with level 0 and trigger 0
- R7: A response with `rsp_ack_i`=1 returns the block to idle. A response with `rsp_ack_i`=0 for any mode except 110 raises `msg_valid_o` again in the next cycle and increments `retry_cnt_o`. `retry_cnt_o` is cleared when a new command is accepted.
- R8: A reject that arrives with `retry_cnt_o` already at MAX_RETRY (7) sends nothing further. It sets the sticky `abort_o`, returns to idle and leaves `retry_cnt_o` at MAX_RETRY.
- R9: A reject of a mode-110 message is not re-sent. It sets the sticky `drop_o` and returns to idle.
- R10: A write while `busy_o` is high is ignored and sets the sticky `overrun_o`. The message in flight keeps its fields.
- R11: `rsp_valid_i` has no effect unless a sent message is awaiting its response.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_vector_i | input | 8 | Command vector |
| cmd_mode_i | input | 3 | Delivery mode |
| cmd_level_i | input | 1 | Level flag |
| cmd_trig_i | input | 1 | Trigger-mode flag |
| cmd_short_i | input | 2 | Destination shorthand |
| cmd_dest_i | input | DEST_W | Destination processor index |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message taken by the bus |
| msg_vector_o | output | 8 | Message vector |
| msg_mode_o | output | 3 | Message delivery mode |
| msg_level_o | output | 1 | Message level flag |
| msg_trig_o | output | 1 | Message trigger flag |
| msg_mask_o | output | NUM_CPUS | Target processor mask |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_ack_i | input | 1 | 1 accepted, 0 rejected |
| busy_o | output | 1 | Command in progress |
| retry_cnt_o | output | RETRY_W | Retries of the current or last command |
| err_rsvd_o | output | 1 | Sticky: reserved command written |
| warn_vec_o | output | 1 | Sticky: vector forced to zero |
| overrun_o | output | 1 | Sticky: write while busy |
| abort_o | output | 1 | Sticky: retry limit exhausted |
| drop_o | output | 1 | Sticky: start-up message rejected |

## Verification
The bench builds the block with NUM_CPUS=8, SELF_ID=5 and MAX_RETRY=7. With the own index set to 5, which is neither the lowest nor the highest bit, the self-only and all-but-self masks differ from any end-bit or reversed-order mistake. Dest indices 0, 5 and 7 also hit both edges and the self position. A limit of 7 makes the abort path reachable in a run of eight rejects, with the counter observed at its top value. Stalling the ready line for a few cycles and injecting stray responses during those stalls brings message hold and response filtering within reach.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VEC_W = 8;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD3  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSVD7  = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } short_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEND = 2'b01,
    ST_WAIT = 2'b10
  } state_e;
endpackage

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int SELF_ID  = 0,
  parameter int DEST_W   = 3
) (
  input  logic [1:0]          short_i,
  input  logic [DEST_W-1:0]   dest_i,
  input  logic                force_all_i,
  output logic [NUM_CPUS-1:0] mask_o
);
  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_bit
    always_comb begin
      if (force_all_i) begin
        mask_o[i] = 1'b1;
      end else begin
        unique case (short_e'(short_i))
          SH_FIELD:  mask_o[i] = (dest_i == DEST_W'(i));
          SH_SELF:   mask_o[i] = (i == SELF_ID);
          SH_ALL:    mask_o[i] = 1'b1;
          SH_OTHERS: mask_o[i] = (i != SELF_ID);
          default:   mask_o[i] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_cmd_check.sv
module ipi_cmd_check
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int SELF_ID  = 0,
  parameter int DEST_W   = 3
) (
  input  logic [VEC_W-1:0]    vector_i,
  input  logic [2:0]          mode_i,
  input  logic                level_i,
  input  logic                trig_i,
  input  logic [1:0]          short_i,
  input  logic [DEST_W-1:0]   dest_i,
  output logic                bad_o,
  output logic                warn_o,
  output logic [VEC_W-1:0]    vector_o,
  output logic [NUM_CPUS-1:0] mask_o
);
  logic is_init, sync_msg, init_bad, zero_req;

  always_comb begin
    is_init  = (mode_i == DM_INIT);
    sync_msg = is_init && !level_i && trig_i;
    init_bad = is_init && !level_i && !trig_i;
    bad_o    = (mode_i == DM_RSVD3) || (mode_i == DM_RSVD7) || init_bad;
    zero_req = (mode_i == DM_SMI) || is_init;
    warn_o   = zero_req && (vector_i != '0);
    vector_o = (zero_req || mode_i == DM_NMI) ? '0 : vector_i;
  end

  ipi_dest_resolve #(
    .NUM_CPUS(NUM_CPUS),
    .SELF_ID (SELF_ID),
    .DEST_W  (DEST_W)
  ) u_dest (
    .short_i    (short_i),
    .dest_i     (dest_i),
    .force_all_i(sync_msg),
    .mask_o     (mask_o)
  );
endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl
  import ipi_pkg::*;
#(
  parameter int MAX_RETRY = 7,
  parameter int RETRY_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_we_i,
  input  logic               cmd_bad_i,
  input  logic               cmd_warn_i,
  input  logic               no_retry_i,
  input  logic               msg_ready_i,
  input  logic               rsp_valid_i,
  input  logic               rsp_ack_i,
  output logic               load_o,
  output logic               msg_valid_o,
  output logic               busy_o,
  output logic [RETRY_W-1:0] retry_cnt_o,
  output logic               err_rsvd_o,
  output logic               warn_vec_o,
  output logic               overrun_o,
  output logic               abort_o,
  output logic               drop_o
);
  localparam logic [RETRY_W-1:0] RetryMax = RETRY_W'(MAX_RETRY);

  state_e             st_q;
  logic [RETRY_W-1:0] retry_q;
  logic               err_q, warn_q, ovr_q, abort_q, drop_q;
  logic               idle, rejected;

  always_comb begin
    idle     = (st_q == ST_IDLE);
    load_o   = cmd_we_i && idle && !cmd_bad_i;
    rejected = (st_q == ST_WAIT) && rsp_valid_i && !rsp_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      retry_q <= '0;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
      ovr_q   <= 1'b0;
      abort_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      if (cmd_we_i && !idle)              ovr_q  <= 1'b1;
      if (cmd_we_i && idle && cmd_bad_i)  err_q  <= 1'b1;
      if (load_o && cmd_warn_i)           warn_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (load_o) begin
          st_q    <= ST_SEND;
          retry_q <= '0;
        end
        ST_SEND: if (msg_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (rsp_ack_i) begin
            st_q <= ST_IDLE;
          end else if (no_retry_i) begin
            drop_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (retry_q == RetryMax) begin
            abort_q <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            retry_q <= retry_q + RETRY_W'(1);
            st_q    <= ST_SEND;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid_o = (st_q == ST_SEND);
  assign busy_o      = !idle;
  assign retry_cnt_o = retry_q;
  assign err_rsvd_o  = err_q;
  assign warn_vec_o  = warn_q;
  assign overrun_o   = ovr_q;
  assign abort_o     = abort_q;
  assign drop_o      = drop_q;

  // R1
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o);

  // R8
  abort_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (retry_cnt_o == RetryMax) && !busy_o);

  // R11
  stray_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && rsp_valid_i |=> $stable(retry_cnt_o) && !$fell(busy_o));

  // R10
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_we_i |=> overrun_o);

  // R9
  sipi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected && no_retry_i |=> !busy_o && !msg_valid_o && drop_o);

  // R7
  resend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected && !no_retry_i && (retry_cnt_o != RetryMax) |=> msg_valid_o);
endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS  = 8,
  parameter int SELF_ID   = 0,
  parameter int MAX_RETRY = 7,
  localparam int DEST_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int RETRY_W  = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_we_i,
  input  logic [7:0]          cmd_vector_i,
  input  logic [2:0]          cmd_mode_i,
  input  logic                cmd_level_i,
  input  logic                cmd_trig_i,
  input  logic [1:0]          cmd_short_i,
  input  logic [DEST_W-1:0]   cmd_dest_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_mode_o,
  output logic                msg_level_o,
  output logic                msg_trig_o,
  output logic [NUM_CPUS-1:0] msg_mask_o,
  input  logic                rsp_valid_i,
  input  logic                rsp_ack_i,
  output logic                busy_o,
  output logic [RETRY_W-1:0]  retry_cnt_o,
  output logic                err_rsvd_o,
  output logic                warn_vec_o,
  output logic                overrun_o,
  output logic                abort_o,
  output logic                drop_o
);
  logic                bad, warn, load;
  logic [VEC_W-1:0]    res_vec;
  logic [NUM_CPUS-1:0] res_mask;

  logic [VEC_W-1:0]    vec_q;
  logic [2:0]          mode_q;
  logic                level_q, trig_q;
  logic [NUM_CPUS-1:0] mask_q;

  ipi_cmd_check #(
    .NUM_CPUS(NUM_CPUS),
    .SELF_ID (SELF_ID),
    .DEST_W  (DEST_W)
  ) u_check (
    .vector_i(cmd_vector_i),
    .mode_i  (cmd_mode_i),
    .level_i (cmd_level_i),
    .trig_i  (cmd_trig_i),
    .short_i (cmd_short_i),
    .dest_i  (cmd_dest_i),
    .bad_o   (bad),
    .warn_o  (warn),
    .vector_o(res_vec),
    .mask_o  (res_mask)
  );

  ipi_send_ctrl #(
    .MAX_RETRY(MAX_RETRY),
    .RETRY_W  (RETRY_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cmd_we_i),
    .cmd_bad_i  (bad),
    .cmd_warn_i (warn),
    .no_retry_i (mode_q == DM_START),
    .msg_ready_i(msg_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_ack_i  (rsp_ack_i),
    .load_o     (load),
    .msg_valid_o(msg_valid_o),
    .busy_o     (busy_o),
    .retry_cnt_o(retry_cnt_o),
    .err_rsvd_o (err_rsvd_o),
    .warn_vec_o (warn_vec_o),
    .overrun_o  (overrun_o),
    .abort_o    (abort_o),
    .drop_o     (drop_o)
  );

  // message captured once per accepted command; retries resend the copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      mode_q  <= '0;
      level_q <= 1'b0;
      trig_q  <= 1'b0;
      mask_q  <= '0;
    end else if (load) begin
      vec_q   <= res_vec;
      mode_q  <= cmd_mode_i;
      level_q <= cmd_level_i;
      trig_q  <= cmd_trig_i;
      mask_q  <= res_mask;
    end
  end

  assign msg_vector_o = vec_q;
  assign msg_mode_o   = mode_q;
  assign msg_level_o  = level_q;
  assign msg_trig_o   = trig_q;
  assign msg_mask_o   = mask_q;

  // R3
  sync_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_mode_o == DM_INIT) && !msg_level_o && msg_trig_o
    |-> (&msg_mask_o) && (msg_vector_o == '0));

  // R4
  zero_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && ((msg_mode_o == DM_SMI) || (msg_mode_o == DM_INIT))
    |-> msg_vector_o == '0);

  // R1
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i
    |=> $stable(msg_vector_o) && $stable(msg_mask_o) && $stable(msg_mode_o));

  // R6
  rsvd_no_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_we_i && ((cmd_mode_i == DM_RSVD3) || (cmd_mode_i == DM_RSVD7))
    |=> !msg_valid_o && err_rsvd_o);

  // R2
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_mask_o != '0 || (NUM_CPUS == 1));
endmodule

// File: tb/ipi_cmd_issuer_test.sv
`timescale 1ns/1ps
module ipi_cmd_issuer_test;
  localparam int NUM_CPUS  = 8;
  localparam int SELF_ID   = 5;
  localparam int MAX_RETRY = 7;
  localparam int DEST_W    = 3;
  localparam int RETRY_W   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                cmd_we = 0;
  logic [7:0]          cmd_vec = 0;
  logic [2:0]          cmd_mode = 0;
  logic                cmd_lvl = 0, cmd_trg = 0;
  logic [1:0]          cmd_sh = 0;
  logic [DEST_W-1:0]   cmd_dst = 0;
  logic                msg_ready = 0, rsp_valid = 0, rsp_ack = 0;
  logic                msg_valid, busy, err_rsvd, warn_vec, overrun, abort_f, drop_f;
  logic [7:0]          msg_vec;
  logic [2:0]          msg_mode;
  logic                msg_lvl, msg_trg;
  logic [NUM_CPUS-1:0] msg_mask;
  logic [RETRY_W-1:0]  retry_cnt;

  ipi_cmd_issuer #(.NUM_CPUS(NUM_CPUS), .SELF_ID(SELF_ID), .MAX_RETRY(MAX_RETRY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_vector_i(cmd_vec),
    .cmd_mode_i(cmd_mode), .cmd_level_i(cmd_lvl), .cmd_trig_i(cmd_trg),
    .cmd_short_i(cmd_sh), .cmd_dest_i(cmd_dst), .msg_valid_o(msg_valid),
    .msg_ready_i(msg_ready), .msg_vector_o(msg_vec), .msg_mode_o(msg_mode),
    .msg_level_o(msg_lvl), .msg_trig_o(msg_trg), .msg_mask_o(msg_mask),
    .rsp_valid_i(rsp_valid), .rsp_ack_i(rsp_ack), .busy_o(busy),
    .retry_cnt_o(retry_cnt), .err_rsvd_o(err_rsvd), .warn_vec_o(warn_vec),
    .overrun_o(overrun), .abort_o(abort_f), .drop_o(drop_f));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model: 0 idle, 1 message offered, 2 awaiting response
  int         m_state = 0, m_retry = 0;
  logic [7:0] m_vec = 0, m_mask = 0;
  logic [2:0] m_mode = 0;
  logic       m_lvl = 0, m_trg = 0;
  bit         m_err = 0, m_warn = 0, m_ovr = 0, m_abort = 0, m_drop = 0;
  int         rej_left = 0, stall = 0, stall_cfg = 0, sends = 0;
  bit         stray = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic decode(input logic [7:0] v, input logic [2:0] md, input logic l, input logic t,
                        input logic [1:0] sh, input logic [2:0] d,
                        output bit bad, output bit w, output logic [7:0] ov, output logic [7:0] om);
    bit sync;
    sync = (md == 5) && !l && t;
    bad  = (md == 3) || (md == 7) || ((md == 5) && !l && !t);
    w    = ((md == 2) || (md == 5)) && (v != 0);
    ov   = (md == 2 || md == 4 || md == 5) ? 8'h00 : v;
    if (sync)         om = 8'hFF;
    else if (sh == 0) om = 8'(1 << d);
    else if (sh == 1) om = 8'(1 << SELF_ID);
    else if (sh == 2) om = 8'hFF;
    else              om = 8'hFF & ~8'(1 << SELF_ID);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_retry = 0; m_vec = 0; m_mask = 0; m_mode = 0; m_lvl = 0; m_trg = 0;
      m_err = 0; m_warn = 0; m_ovr = 0; m_abort = 0; m_drop = 0;
    end else begin
      case (m_state)
        0: if (cmd_we) begin
          bit bad, w; logic [7:0] ov, om;
          decode(cmd_vec, cmd_mode, cmd_lvl, cmd_trg, cmd_sh, cmd_dst, bad, w, ov, om);
          if (bad) m_err = 1;
          else begin
            if (w) m_warn = 1;
            m_vec = ov; m_mask = om; m_mode = cmd_mode; m_lvl = cmd_lvl; m_trg = cmd_trg;
            m_retry = 0; m_state = 1; stall = stall_cfg;
          end
        end
        1: begin
          if (cmd_we) m_ovr = 1;
          if (msg_ready) begin m_state = 2; sends++; end
          else if (stall > 0) stall--;
        end
        default: begin
          if (cmd_we) m_ovr = 1;
          if (rsp_valid) begin
            if (rsp_ack) m_state = 0;
            else begin
              if (rej_left > 0) rej_left--;
              if (m_mode == 6) begin m_drop = 1; m_state = 0; end
              else if (m_retry == MAX_RETRY) begin m_abort = 1; m_state = 0; end
              else begin m_retry++; m_state = 1; stall = stall_cfg; end
            end
          end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1", "msg_valid", msg_valid, m_state == 1);
    chk("R1", "busy", busy, m_state != 0);
    chk("R1", "mode", msg_mode, m_mode);
    chk("R1", "level", msg_lvl, m_lvl);
    chk("R1", "trig", msg_trg, m_trg);
    chk("R5", "vector", msg_vec, m_vec);
    chk("R2", "mask", msg_mask, m_mask);
    chk("R7", "retry_cnt", retry_cnt, m_retry);
    chk("R6", "err_rsvd", err_rsvd, m_err);
    chk("R4", "warn_vec", warn_vec, m_warn);
    chk("R10", "overrun", overrun, m_ovr);
    chk("R8", "abort", abort_f, m_abort);
    chk("R9", "drop", drop_f, m_drop);
  end

  // bus side: ready after stall, responses only while awaiting (plus stray ones)
  always @(negedge clk) begin
    msg_ready <= (m_state == 1) && (stall == 0);
    rsp_valid <= (m_state == 2) || (stray && m_state == 1);
    rsp_ack   <= (m_state == 2) && (rej_left == 0);
  end

  task automatic issue(input logic [7:0] v, input logic [2:0] md, input logic l, input logic t,
                       input logic [1:0] sh, input logic [2:0] d, input int rej, input int stl,
                       input bit sty);
    rej_left = rej; stall_cfg = stl; stray = sty;
    @(negedge clk);
    cmd_we = 1; cmd_vec = v; cmd_mode = md; cmd_lvl = l; cmd_trg = t; cmd_sh = sh; cmd_dst = d;
    @(negedge clk);
    cmd_we = 0;
    while (m_state != 0) @(negedge clk);
    @(negedge clk);
    stray = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset outputs",
        int'({msg_valid, busy, err_rsvd, warn_vec, overrun, abort_f, drop_f}), 0);
    chk("R12", "reset msg", int'({msg_vec, msg_mask, msg_mode, retry_cnt}), 0);
    rst_n = 1;
    @(negedge clk);

    issue(8'h41, 3'd0, 1, 0, 2'd0, 3'd3, 0, 0, 0);          // R1 fixed
    issue(8'h55, 3'd1, 1, 1, 2'd1, 3'd0, 0, 2, 0);          // R1 hold under stall
    issue(8'hAA, 3'd4, 0, 0, 2'd2, 3'd0, 0, 0, 0);          // R5 nmi
    chk("R5", "nmi no warn", warn_vec, 0);
    issue(8'h9F, 3'd6, 0, 0, 2'd3, 3'd0, 0, 0, 0);          // R5 startup keeps vector
    issue(8'h20, 3'd0, 0, 0, 2'd0, 3'd7, 2, 3, 1);          // R7 + R11 stray responses
    chk("R7", "two retries", retry_cnt, 2);
    chk("R11", "no abort from stray", abort_f, 0);
    issue(8'h00, 3'd5, 0, 1, 2'd1, 3'd2, 0, 0, 0);          // R3 sync broadcast
    chk("R3", "sync mask", msg_mask, 8'hFF);
    issue(8'h33, 3'd3, 0, 0, 2'd0, 3'd1, 0, 0, 0);          // R6 reserved 011
    chk("R6", "err after 011", err_rsvd, 1);
    chk("R6", "idle after 011", busy, 0);
    issue(8'h33, 3'd7, 0, 0, 2'd0, 3'd1, 0, 0, 0);          // R6 reserved 111
    issue(8'h33, 3'd5, 0, 0, 2'd0, 3'd1, 0, 0, 0);          // R6 init level0 trig0
    chk("R6", "no message on 101/00", msg_mode, 3'd5);
    chk("R6", "kept sync mask", msg_mask, 8'hFF);
    issue(8'h12, 3'd2, 0, 0, 2'd0, 3'd4, 0, 0, 0);          // R4 smi forced zero
    chk("R4", "smi vector", msg_vec, 0);
    chk("R4", "warn set", warn_vec, 1);
    issue(8'h7E, 3'd5, 1, 0, 2'd0, 3'd6, 1, 0, 0);          // R4 init with retry
    issue(8'h01, 3'd0, 0, 0, 2'd0, 3'd1, 8, 0, 0);          // R8 abort
    chk("R8", "abort set", abort_f, 1);
    chk("R8", "retry at max", retry_cnt, MAX_RETRY);
    s0 = sends;
    issue(8'hC3, 3'd6, 0, 0, 2'd0, 3'd5, 1, 0, 0);          // R9 startup reject
    chk("R9", "drop set", drop_f, 1);
    chk("R9", "single send", sends - s0, 1);
    chk("R9", "retry zero", retry_cnt, 0);
    // R10 write while busy
    rej_left = 0; stall_cfg = 4;
    @(negedge clk);
    cmd_we = 1; cmd_vec = 8'h66; cmd_mode = 3'd0; cmd_lvl = 0; cmd_trg = 0; cmd_sh = 2'd0; cmd_dst = 3'd2;
    @(negedge clk);
    cmd_vec = 8'h99; cmd_dst = 3'd6; cmd_sh = 2'd2;
    @(negedge clk);
    cmd_we = 0;
    chk("R10", "in-flight vector", msg_vec, 8'h66);
    chk("R10", "in-flight mask", msg_mask, 8'h04);
    while (m_state != 0) @(negedge clk);
    chk("R10", "overrun set", overrun, 1);
    // R2 all shorthands, edges and self index
    for (int sh = 0; sh < 4; sh++) begin
      issue(8'h30, 3'd0, 0, 0, 2'(sh), 3'd0, 0, 0, 0);
      issue(8'h31, 3'd1, 0, 1, 2'(sh), 3'd7, 0, 1, 0);
      issue(8'h32, 3'd6, 1, 0, 2'(sh), 3'd5, 0, 0, 0);
    end
    chk("R2", "others mask", msg_mask, 8'hDF);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule